// File: doc/BRIEF.md
# Out-of-Order Per-Bank Refresh Scheduler

This block sits inside a memory controller that drives one rank of DRAM with per-bank refresh. A free-running interval timer gives every bank one more owed refresh each interval, and each bank keeps these owed refreshes in a credit counter that saturates at a cap. The block picks a bank to refresh from whatever state the access side reports. It prefers banks whose request queues are empty. While the controller drains a batch of writes, it also takes banks that still hold queued requests. A bank whose debt has reached the cap is forced, whatever its queue holds. Banks are not visited in a fixed rotation. A rotating pointer only breaks ties inside one priority level.

A refresh is offered on `refReq` together with `refBank`, and it is issued when the command slot is granted (`slotGrant`). The refreshed bank's bit in `blockedMask` then stays high for the refresh busy time so that the access scheduler holds that bank off, while the other banks keep serving accesses. A mode input switches the block to whole-rank refresh. In that mode one command refreshes and blocks every bank.

Top module: `ooo_bank_refresh`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) clears all credits, busy counters, the pointer and the interval timer. While in reset and after it, `blockedMask` is all zero and `refReq` is 0 until the first interval has elapsed.
- R2: Every INTERVAL clock edges after reset release, every bank gains one owed refresh. Credits saturate at CREDIT_CAP (8), so a bank never owes more than 8 refreshes.
- R3: In per-bank mode, a grant while `refReq`=1 refreshes exactly bank `refBank`. Its `blockedMask` bit is 1 for REF_CYCLES cycles starting the cycle after the grant, and it does not change the other bits.
- R4: A bank whose `blockedMask` bit is 1 is never offered on `refBank`.
- R5: With `writeDrain`=0, a pending bank that is not at the cap is offered only if its `bankHasReq` bit is 0. If only banks with queued requests are pending, `refReq` is 0.
- R6: With `writeDrain`=1, pending banks that have queued requests also become eligible, at a priority below empty-queue banks.
- R7: A bank whose credit equals the cap is eligible even with queued requests, and such banks take priority over empty-queue and drain candidates.
- R8: Within one priority level, the chosen bank is the first candidate at or after a pointer, wrapping from NUM_BANKS-1 to 0. After each per-bank issue the pointer moves to the issued bank plus one (modulo NUM_BANKS). The pointer starts at 0.
- R9: With `allBankMode`=1, `refReq` and `refAll` are 1 when any bank owes a refresh, no bank is blocked and no `bankBusy` bit is set. A grant then sets every `blockedMask` bit for REF_ALL_CYCLES cycles and removes one credit from every bank that owes one.
- R10: A bank with its `bankBusy` bit set is never offered in per-bank mode, and any set `bankBusy` bit holds off a whole-rank refresh.
- R11: At most one refresh command is issued per cycle, and only on a cycle with `slotGrant`=1. Without a grant, the offer stays unchanged and no credit is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| allBankMode | input | 1 | 1 = whole-rank refresh fallback |
| writeDrain | input | 1 | Controller is draining a write batch |
| bankHasReq | input | NUM_BANKS | Per-bank request queue non-empty |
| bankBusy | input | NUM_BANKS | Per-bank access in flight; bank may not be refreshed |
| slotGrant | input | 1 | Command slot granted to the refresh scheduler this cycle |
| refReq | output | 1 | A refresh is ready to issue |
| refAll | output | 1 | The offered refresh covers the whole rank |
| refBank | output | IDX_W | Bank offered for per-bank refresh |
| blockedMask | output | NUM_BANKS | Banks the access scheduler must hold off |

## Verification
Several selection rules can apply in the same cycle. In some cycles a capped bank, an empty-queue bank and a drain candidate all exist together. In others, the pointer favours a bank that a higher level overrides. The bench builds the first case by leaving two banks one credit short of the cap while the pointer sits on one of them, and builds the second by mixing queued, busy and just-refreshed banks in a stepped table. Each cycle, the offered bank and the blocked mask are compared with values worked out by hand from the priority order and the pointer.

// File: rtl/ooo_refresh_pkg.sv
package ooo_refresh_pkg;

  // Strobes from the selector to the credit/busy datapath.
  typedef struct packed {
    logic fire;     // a refresh command is issued this cycle
    logic allBank;  // the issued command covers every bank
  } refStrobe_t;

  // Priority level of the current per-bank candidate set.
  typedef enum logic [1:0] {
    LVL_NONE  = 2'd0,
    LVL_DRAIN = 2'd1,
    LVL_IDLE  = 2'd2,
    LVL_FORCE = 2'd3
  } refLevel_t;

endpackage

// File: rtl/ref_credit_dp.sv
module ref_credit_dp
  import ooo_refresh_pkg::*;
#(
  parameter int NUM_BANKS      = 8,
  parameter int CREDIT_CAP     = 8,
  parameter int INTERVAL       = 3900,
  parameter int REF_CYCLES     = 90,
  parameter int REF_ALL_CYCLES = 280,
  localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CRED_W   = $clog2(CREDIT_CAP + 1),
  localparam int BUSY_MAX = (REF_CYCLES > REF_ALL_CYCLES) ? REF_CYCLES : REF_ALL_CYCLES,
  localparam int BUSY_W   = $clog2(BUSY_MAX + 1),
  localparam int IV_W     = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  refStrobe_t           strobe,
  input  logic [IDX_W-1:0]     issueBank,
  output logic [NUM_BANKS-1:0] creditPending,
  output logic [NUM_BANKS-1:0] creditFull,
  output logic [NUM_BANKS-1:0] blockedMask
);

  localparam logic [CRED_W-1:0] CAP_V      = CRED_W'(CREDIT_CAP);
  localparam logic [BUSY_W-1:0] LOAD_BANK  = BUSY_W'(REF_CYCLES);
  localparam logic [BUSY_W-1:0] LOAD_ALL   = BUSY_W'(REF_ALL_CYCLES);
  localparam logic [IV_W-1:0]   IV_LAST    = IV_W'(INTERVAL - 1);

  // Interval timer: one tick per INTERVAL cycles.
  logic [IV_W-1:0] ivCnt;
  logic            ivTick;

  assign ivTick = (ivCnt == IV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ivCnt <= '0;
    else if (ivTick) ivCnt <= '0;
    else             ivCnt <= ivCnt + IV_W'(1);
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [CRED_W-1:0] credit;
    logic [BUSY_W-1:0] busyCnt;
    logic              hit;
    logic              dec;

    assign hit = strobe.fire && (strobe.allBank || (issueBank == IDX_W'(g)));
    assign dec = hit && (credit != '0);

    // Owed-refresh credit: +1 per tick, -1 per issue, saturating at the cap.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        credit <= '0;
      end else begin
        unique case ({ivTick, dec})
          2'b10:   if (credit != CAP_V) credit <= credit + CRED_W'(1);
          2'b01:   credit <= credit - CRED_W'(1);
          default: credit <= credit;
        endcase
      end
    end

    // Refresh busy time: loaded on issue, counts down to zero.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               busyCnt <= '0;
      else if (hit)             busyCnt <= strobe.allBank ? LOAD_ALL : LOAD_BANK;
      else if (busyCnt != '0)   busyCnt <= busyCnt - BUSY_W'(1);
    end

    assign creditPending[g] = (credit != '0);
    assign creditFull[g]    = (credit == CAP_V);
    assign blockedMask[g]   = (busyCnt != '0);

    // R2: a capped credit stays capped across a tick with no issue.
    p_cap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ivTick && credit == CAP_V && !hit) |=> (credit == CAP_V));

    // R4: the datapath is never told to refresh a bank that is still busy.
    p_no_hit_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !strobe.allBank) |-> (busyCnt == '0));
  end

  // R3: the issued bank is blocked in the following cycle.
  p_blocked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fire && !strobe.allBank) |=> blockedMask[$past(issueBank)]);

  // R9: a whole-rank refresh blocks every bank.
  p_all_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fire && strobe.allBank) |=> (&blockedMask));

  // R11: outside whole-rank issue, at most one bank becomes blocked per cycle.
  p_one_new_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.fire && strobe.allBank) |=>
      ($countones(blockedMask & ~$past(blockedMask)) <= 1));

endmodule

// File: rtl/ref_pick_ctrl.sv
module ref_pick_ctrl
  import ooo_refresh_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 allBankMode,
  input  logic                 writeDrain,
  input  logic                 slotGrant,
  input  logic [NUM_BANKS-1:0] bankHasReq,
  input  logic [NUM_BANKS-1:0] bankBusy,
  input  logic [NUM_BANKS-1:0] creditPending,
  input  logic [NUM_BANKS-1:0] creditFull,
  input  logic [NUM_BANKS-1:0] blockedMask,
  output logic                 refReq,
  output logic                 refAll,
  output logic [IDX_W-1:0]     refBank,
  output refStrobe_t           strobe
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BANKS - 1);

  logic [IDX_W-1:0]     rrPtr;
  logic [NUM_BANKS-1:0] eligible;
  logic [NUM_BANKS-1:0] forceSet;
  logic [NUM_BANKS-1:0] idleSet;
  logic [NUM_BANKS-1:0] drainSet;
  logic [NUM_BANKS-1:0] pickSet;
  logic [IDX_W-1:0]     pickBank;
  refLevel_t            level;
  logic                 allReady;

  // First set bit at or after the start index, wrapping around.
  function automatic logic [IDX_W-1:0] rrPick(input logic [NUM_BANKS-1:0] cand,
                                              input logic [IDX_W-1:0] start);
    logic [IDX_W-1:0] sel;
    int pos;
    sel = '0;
    for (int off = NUM_BANKS - 1; off >= 0; off--) begin
      pos = int'(start) + off;
      if (pos >= NUM_BANKS) pos = pos - NUM_BANKS;
      if (cand[pos]) sel = IDX_W'(pos);
    end
    return sel;
  endfunction

  assign eligible = creditPending & ~blockedMask & ~bankBusy;
  assign forceSet = eligible & creditFull;
  assign idleSet  = eligible & ~bankHasReq;
  assign drainSet = writeDrain ? eligible : '0;

  always_comb begin
    if (|forceSet) begin
      level   = LVL_FORCE;
      pickSet = forceSet;
    end else if (|idleSet) begin
      level   = LVL_IDLE;
      pickSet = idleSet;
    end else if (|drainSet) begin
      level   = LVL_DRAIN;
      pickSet = drainSet;
    end else begin
      level   = LVL_NONE;
      pickSet = '0;
    end
  end

  assign pickBank = rrPick(pickSet, rrPtr);
  assign allReady = (|creditPending) && !(|blockedMask) && !(|bankBusy);

  assign refReq         = allBankMode ? allReady : (level != LVL_NONE);
  assign refAll         = allBankMode && allReady;
  assign refBank        = allBankMode ? '0 : pickBank;
  assign strobe.fire    = refReq && slotGrant;
  assign strobe.allBank = allBankMode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrPtr <= '0;
    end else if (strobe.fire && !allBankMode) begin
      rrPtr <= (refBank == LAST_IDX) ? '0 : refBank + IDX_W'(1);
    end
  end

  // R4: a blocked bank is never offered.
  p_not_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (refReq && !allBankMode) |-> !blockedMask[refBank]);

  // R10: a bank with an access in flight is never offered.
  p_busy_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (refReq && !allBankMode) |-> !bankBusy[refBank]);

  // R7: if any capped bank is free, the offered bank is capped.
  p_force_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (refReq && !allBankMode && |(creditFull & ~blockedMask & ~bankBusy))
      |-> creditFull[refBank]);

  // R5: outside a drain, an uncapped offered bank has an empty queue.
  p_idle_pref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (refReq && !allBankMode && !writeDrain && !creditFull[refBank])
      |-> !bankHasReq[refBank]);

  // R9: whole-rank offers only when nothing is blocked or busy.
  p_all_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    refAll |-> (blockedMask == '0 && bankBusy == '0));

endmodule

// File: rtl/ooo_bank_refresh.sv
module ooo_bank_refresh
  import ooo_refresh_pkg::*;
#(
  parameter int NUM_BANKS      = 8,
  parameter int CREDIT_CAP     = 8,
  parameter int INTERVAL       = 3900,
  parameter int REF_CYCLES     = 90,
  parameter int REF_ALL_CYCLES = 280,
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 allBankMode,
  input  logic                 writeDrain,
  input  logic [NUM_BANKS-1:0] bankHasReq,
  input  logic [NUM_BANKS-1:0] bankBusy,
  input  logic                 slotGrant,
  output logic                 refReq,
  output logic                 refAll,
  output logic [IDX_W-1:0]     refBank,
  output logic [NUM_BANKS-1:0] blockedMask
);

  refStrobe_t           strobe;
  logic [NUM_BANKS-1:0] creditPending;
  logic [NUM_BANKS-1:0] creditFull;

  ref_pick_ctrl #(
    .NUM_BANKS(NUM_BANKS)
  ) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .allBankMode  (allBankMode),
    .writeDrain   (writeDrain),
    .slotGrant    (slotGrant),
    .bankHasReq   (bankHasReq),
    .bankBusy     (bankBusy),
    .creditPending(creditPending),
    .creditFull   (creditFull),
    .blockedMask  (blockedMask),
    .refReq       (refReq),
    .refAll       (refAll),
    .refBank      (refBank),
    .strobe       (strobe)
  );

  ref_credit_dp #(
    .NUM_BANKS     (NUM_BANKS),
    .CREDIT_CAP    (CREDIT_CAP),
    .INTERVAL      (INTERVAL),
    .REF_CYCLES    (REF_CYCLES),
    .REF_ALL_CYCLES(REF_ALL_CYCLES)
  ) dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .issueBank    (refBank),
    .creditPending(creditPending),
    .creditFull   (creditFull),
    .blockedMask  (blockedMask)
  );

endmodule

// File: tb/ooo_bank_refresh_tb.sv
`timescale 1ns/100ps
module ooo_bank_refresh_tb_top;

  localparam int NB  = 4;
  localparam int IVL = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       allBankMode = 1'b0;
  logic       writeDrain = 1'b0;
  logic [3:0] bankHasReq = '0;
  logic [3:0] bankBusy = '0;
  logic       slotGrant = 1'b0;
  logic       refReq;
  logic       refAll;
  logic [1:0] refBank;
  logic [3:0] blockedMask;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ooo_bank_refresh #(
    .NUM_BANKS(NB), .CREDIT_CAP(8), .INTERVAL(IVL),
    .REF_CYCLES(3), .REF_ALL_CYCLES(6)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .allBankMode(allBankMode), .writeDrain(writeDrain),
    .bankHasReq(bankHasReq), .bankBusy(bankBusy), .slotGrant(slotGrant),
    .refReq(refReq), .refAll(refAll), .refBank(refBank), .blockedMask(blockedMask)
  );

  typedef struct packed {
    logic [3:0] hasReq;
    logic [3:0] busy;
    logic       drain;
    logic       grant;
    logic       expReq;
    logic [1:0] expBank;
    logic [3:0] expBlk;
  } row_t;

  // Per-bank stepping, credits start at 2 each, pointer at 0, REF_CYCLES = 3.
  localparam row_t TBL [14] = '{
    '{4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 4'b0000},
    '{4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd0, 4'b0000},
    '{4'b0001, 4'b0000, 1'b0, 1'b1, 1'b1, 2'd1, 4'b0000},
    '{4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 2'd2, 4'b0010},
    '{4'b1000, 4'b0001, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0110},
    '{4'b1000, 4'b0001, 1'b1, 1'b1, 1'b1, 2'd3, 4'b0110},
    '{4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 2'd0, 4'b1100},
    '{4'b0010, 4'b0000, 1'b0, 1'b1, 1'b1, 2'd2, 4'b1001},
    '{4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 2'd1, 4'b1101},
    '{4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 2'd3, 4'b0111},
    '{4'b1000, 4'b0000, 1'b0, 1'b1, 1'b1, 2'd0, 4'b0110},
    '{4'b1000, 4'b0000, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0011},
    '{4'b1000, 4'b0000, 1'b1, 1'b1, 1'b1, 2'd3, 4'b0001},
    '{4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 2'd0, 4'b1001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idleInputs();
    writeDrain = 1'b0; bankHasReq = '0; bankBusy = '0; slotGrant = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int firstReq;
    int issued;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 blocked in reset", blockedMask, 0);
    chk("R1 refReq in reset", refReq, 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 blocked after reset", blockedMask, 0);

    // R2: first owed refresh appears after exactly one interval.
    firstReq = -1;
    for (int n = 1; n <= 200; n++) begin
      @(negedge clk); #1;
      if (refReq && firstReq < 0) begin firstReq = n; break; end
    end
    chk("R2 edges to first refresh", firstReq, IVL);
    chk("R8 pointer starts at bank 0", refBank, 0);
    chk("R9 refAll low in per-bank mode", refAll, 0);

    // Let credits reach 2 (negedge after edge 128).
    repeat (64) @(negedge clk);
    for (int i = 0; i < 14; i++) begin
      bankHasReq = TBL[i].hasReq; bankBusy = TBL[i].busy;
      writeDrain = TBL[i].drain;  slotGrant = TBL[i].grant;
      #1;
      chk($sformatf("R5/R6/R10/R11 refReq row %0d", i), refReq, TBL[i].expReq);
      if (TBL[i].expReq)
        chk($sformatf("R4/R8 refBank row %0d", i), refBank, TBL[i].expBank);
      chk($sformatf("R3 blockedMask row %0d", i), blockedMask, TBL[i].expBlk);
      @(negedge clk);
    end
    idleInputs();

    // Negedge after edge 200: credits are 1 each.
    repeat (58) @(negedge clk);
    writeDrain = 1'b1; bankBusy = 4'b0111; bankHasReq = 4'b1111; slotGrant = 1'b1;
    #1;
    chk("R6/R10 drain picks free bank", refReq, 1);
    chk("R6/R10 drain bank", refBank, 3);
    @(negedge clk);
    bankBusy = 4'b1011;
    #1;
    chk("R6 drain second bank", refBank, 2);
    @(negedge clk);
    writeDrain = 1'b0; bankBusy = '0; slotGrant = 1'b0; bankHasReq = 4'b1111;
    // Credits now [b0..b3] = 1,1,0,0; pointer at 3.

    repeat (437) @(negedge clk);   // after edge 639: credits 7,7,6,6
    #1;
    chk("R5 queued uncapped banks not offered", refReq, 0);
    @(negedge clk);                // after edge 640: credits 8,8,7,7
    bankHasReq = 4'b0100;
    #1;
    chk("R7 capped bank offered", refReq, 1);
    chk("R7 capped bank beats idle bank at pointer", refBank, 0);
    bankHasReq = '0;

    // Tick at edge 704 saturates all banks at 8.
    repeat (64) @(negedge clk);    // after edge 704
    issued = 0;
    slotGrant = 1'b1;
    for (int c = 0; c < 60; c++) begin
      #1;
      if (refReq) issued++;
      @(negedge clk);
    end                            // after edge 764
    slotGrant = 1'b0;
    #1;
    chk("R2 saturated credit count issued", issued, 32);
    chk("R2 no credit left", refReq, 0);

    // Whole-rank fallback.
    allBankMode = 1'b1;
    repeat (4) @(negedge clk);     // after edge 768
    #1;
    chk("R9 whole-rank offer", refReq, 1);
    chk("R9 refAll", refAll, 1);
    @(negedge clk);
    bankBusy = 4'b0100;
    #1;
    chk("R10 busy bank holds whole-rank", refReq, 0);
    @(negedge clk);
    bankBusy = '0; slotGrant = 1'b1;
    #1;
    chk("R9 whole-rank ready", refReq, 1);
    @(negedge clk);                // issued at edge 771
    slotGrant = 1'b0;
    #1;
    chk("R9 all banks blocked", blockedMask, 4'b1111);
    repeat (5) @(negedge clk);
    #1;
    chk("R9 blocked for full busy time", blockedMask, 4'b1111);
    @(negedge clk);
    #1;
    chk("R9 block released", blockedMask, 4'b0000);
    chk("R9 credits consumed", refReq, 0);

    // Reset while a whole-rank refresh is in progress.
    repeat (55) @(negedge clk);    // after edge 832
    slotGrant = 1'b1;
    @(negedge clk);
    slotGrant = 1'b0;
    #1;
    chk("R9 second whole-rank block", blockedMask, 4'b1111);
    rst_n = 1'b0;
    #1;
    chk("R1 reset clears blocked", blockedMask, 0);
    chk("R1 reset clears offer", refReq, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule